// File: doc/BRIEF.md
# SIMD Warp Issue Scheduler

This block decides, every clock cycle, which warp feeds a row of scalar SIMD lanes and which of that warp's threads do real work in that cycle. A warp is a bundle of threads that share one instruction. The lane row is narrower than the warp, so one warp instruction is spread over several back-to-back cycles. Each cycle covers one group of lanes' worth of threads. With the defaults (32 threads, 8 lanes) an instruction takes four cycles.

Context for every resident warp stays in the block: a valid bit and a per-thread activity mask. Switching from one warp to another therefore costs no cycles. At each instruction boundary a round-robin search picks the next warp among those that are both resident and flagged ready by the outside. A warp that is waiting, for example on memory, is simply passed over. The activity mask gates the lane enables group by group, which is how divergent conditional code is carried out. A group whose threads are all inactive still takes its cycle with every lane disabled, so the cadence of the instruction never changes.

Software outside the block uses a launch command to place a warp in a slot with its mask, and a retire command to free the slot. The per-cycle outputs (valid, warp number, group index, lane enables, last-cycle marker) drive operand fetch and the lanes directly.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, issue_valid, lane_en and issue_last are all zero. Reset clears every warp's resident bit, so no warp issues after reset until one is launched.
- R2: Every issued instruction lasts exactly WARP_SIZE/NUM_LANES consecutive cycles (4 by default) with issue_valid high. issue_group counts 0,1,2,3 and issue_warp stays the same throughout. issue_last is high only in the group-3 cycle.
- R3: In the cycle with issue_group = g, bit i of lane_en equals bit 8*g+i of the warp's activity mask. Thread t is bit t of the 32-bit mask.
- R4: A group whose 8 mask bits are all zero still takes its cycle, with issue_valid high and lane_en = 0.
- R5: A warp is eligible when its resident bit is set and its ready bit is high. A new warp is chosen only when the block is idle or at the clock edge that ends group 3. If a warp is eligible there, its group 0 follows with no idle cycle.
- R6: The choice is round-robin. The search starts at the warp numbered one above the last chosen warp, modulo NUM_WARPS, and goes upward with wrap-around. After reset it starts at warp 0.
- R7: A warp that is not ready, or not resident, is never issued. When no warp is eligible at a choice point, issue_valid drops and lane_en is 0.
- R8: A launch (launch_valid with launch_id) stores launch_mask and sets the resident bit from the next cycle on. The mask used by an instruction is the one stored when that instruction was chosen: a launch made in the choosing cycle, or during the instruction, affects only later instructions.
- R9: A retire (retire_valid with retire_id) clears the resident bit from the next cycle on. If the same cycle carries a launch to the same warp, the launch wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | NUM_WARPS | Per-warp ready flags |
| launch_valid | input | 1 | Launch command strobe |
| launch_id | input | WID_W | Warp slot to launch |
| launch_mask | input | WARP_SIZE | Activity mask of the launched warp |
| retire_valid | input | 1 | Retire command strobe |
| retire_id | input | WID_W | Warp slot to retire |
| issue_valid | output | 1 | A warp group issues this cycle |
| issue_warp | output | WID_W | Warp being issued |
| issue_group | output | GRP_W | Thread group index within the instruction |
| lane_en | output | NUM_LANES | Per-lane enable for this cycle |
| issue_last | output | 1 | Final cycle of the warp instruction |

## Verification
The bench builds the block with its defaults: 24 warp slots, 32-thread warps and 8 lanes, which gives four groups per instruction and 5-bit warp numbers. With 24 slots the wrap from the top slot (23) back to slot 0 is reachable, as is the gap between slot 23 and the end of the 5-bit number space. With four groups per instruction, mask patterns can place empty groups at the start, in the middle and at the end of an instruction. The launch table mixes full, empty and sparse masks across non-adjacent slots, so the round-robin order, the back-to-back handover and the per-group lane gating are all checked against hand-computed values.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Width of an index able to address n items; never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/warp_ctx_table.sv
module warp_ctx_table
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int WARP_SIZE = 32,
  parameter int WID_W     = idx_width(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 launch_valid,
  input  logic [WID_W-1:0]     launch_id,
  input  logic [WARP_SIZE-1:0] launch_mask,
  input  logic                 retire_valid,
  input  logic [WID_W-1:0]     retire_id,
  input  logic [WID_W-1:0]     rd_id,
  output logic [WARP_SIZE-1:0] rd_mask,
  output logic [NUM_WARPS-1:0] ctx_valid
);

  localparam logic [WID_W-1:0] LAST_ID = WID_W'(NUM_WARPS - 1);

  // Mask store: one write port, no reset, so it maps onto distributed RAM.
  logic [WARP_SIZE-1:0] mask_mem [NUM_WARPS];

  logic launch_ok;
  logic retire_ok;
  assign launch_ok = launch_valid && (launch_id <= LAST_ID);
  assign retire_ok = retire_valid && (retire_id <= LAST_ID);

  always_ff @(posedge clk) begin
    if (launch_ok) mask_mem[launch_id] <= launch_mask;
  end

  // Read returns the stored value; a write in the same cycle shows next cycle.
  assign rd_mask = mask_mem[rd_id];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic hit_launch;
    logic hit_retire;
    assign hit_launch = launch_ok && (launch_id == WID_W'(w));
    assign hit_retire = retire_ok && (retire_id == WID_W'(w));
    always_ff @(posedge clk) begin
      if (rst)             ctx_valid[w] <= 1'b0;
      else if (hit_launch) ctx_valid[w] <= 1'b1;   // launch beats retire
      else if (hit_retire) ctx_valid[w] <= 1'b0;
    end
  end

  // R8: a launch makes the slot resident and holds its mask next cycle.
  p_launch_sets_r8: assert property (@(posedge clk) disable iff (rst)
    launch_ok |=> ctx_valid[$past(launch_id)]
                  && (mask_mem[$past(launch_id)] == $past(launch_mask)));

  // R9: a retire without a colliding launch empties the slot.
  p_retire_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (retire_ok && !(launch_ok && launch_id == retire_id))
      |=> !ctx_valid[$past(retire_id)]);

endmodule

// File: rtl/warp_rr_picker.sv
module warp_rr_picker
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int WID_W     = idx_width(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] elig,
  input  logic                 take,
  output logic [WID_W-1:0]     grant,
  output logic                 grant_valid
);

  localparam logic [WID_W-1:0] LAST_ID = WID_W'(NUM_WARPS - 1);

  logic [WID_W-1:0] ptr;

  // Scan upward from ptr with wrap-around; the first eligible slot wins.
  always_comb begin
    int idx;
    grant_valid = 1'b0;
    grant       = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      idx = int'(ptr) + i;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!grant_valid && elig[idx]) begin
        grant_valid = 1'b1;
        grant       = WID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (take) ptr <= (grant == LAST_ID) ? '0 : grant + 1'b1;
  end

  // R7: only an eligible slot is ever offered.
  p_grant_elig_r7: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> elig[grant]);

  // R7: with nothing eligible, nothing is offered.
  p_grant_none_r7: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |-> !grant_valid);

  // R6: the search pointer stays within the slot range.
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST_ID);

endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
  import warp_sched_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  parameter int WID_W     = 5,
  parameter int GROUPS    = WARP_SIZE / NUM_LANES,
  parameter int GRP_W     = idx_width(GROUPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 grant_valid,
  input  logic [WID_W-1:0]     grant,
  input  logic [WARP_SIZE-1:0] sel_mask,
  output logic                 take,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic [GRP_W-1:0]     issue_group,
  output logic [NUM_LANES-1:0] lane_en,
  output logic                 issue_last
);

  localparam logic [GRP_W-1:0] LAST_GRP  = GRP_W'(GROUPS - 1);
  localparam bit               ONE_GROUP = (GROUPS == 1);

  logic [WARP_SIZE-1:0] cur_mask;
  logic [GRP_W-1:0]     next_grp;

  // A choice is made when idle or while the final group is on the outputs.
  assign take     = grant_valid && (!issue_valid || issue_last);
  assign next_grp = issue_group + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_group <= '0;
      lane_en     <= '0;
      issue_last  <= 1'b0;
      cur_mask    <= '0;
    end else if (take) begin
      issue_valid <= 1'b1;
      issue_warp  <= grant;
      issue_group <= '0;
      cur_mask    <= sel_mask;
      lane_en     <= sel_mask[NUM_LANES-1:0];
      issue_last  <= ONE_GROUP;
    end else if (issue_valid && !issue_last) begin
      issue_group <= next_grp;
      lane_en     <= cur_mask[next_grp*NUM_LANES +: NUM_LANES];
      issue_last  <= (next_grp == LAST_GRP);
    end else begin
      issue_valid <= 1'b0;
      issue_group <= '0;
      lane_en     <= '0;
      issue_last  <= 1'b0;
    end
  end

  // R2: the last-cycle marker coincides with the final group.
  p_last_grp_r2: assert property (@(posedge clk) disable iff (rst)
    issue_last |-> issue_valid && (issue_group == LAST_GRP));

  // R2: inside an instruction the group steps by one on the same warp.
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_last)
      |=> issue_valid && (issue_group == GRP_W'($past(issue_group) + 1'b1))
          && (issue_warp == $past(issue_warp)));

  // R5: an eligible warp at the final group starts with no idle cycle.
  p_no_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_last && grant_valid)
      |=> issue_valid && (issue_group == '0));

  // R7: lanes are quiet whenever nothing issues.
  p_idle_lanes_r7: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> (lane_en == '0) && !issue_last);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  parameter int GROUPS    = WARP_SIZE / NUM_LANES,
  parameter int WID_W     = idx_width(NUM_WARPS),
  parameter int GRP_W     = idx_width(GROUPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] ready,
  input  logic                 launch_valid,
  input  logic [WID_W-1:0]     launch_id,
  input  logic [WARP_SIZE-1:0] launch_mask,
  input  logic                 retire_valid,
  input  logic [WID_W-1:0]     retire_id,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic [GRP_W-1:0]     issue_group,
  output logic [NUM_LANES-1:0] lane_en,
  output logic                 issue_last
);

  logic [NUM_WARPS-1:0] ctx_valid;
  logic [NUM_WARPS-1:0] elig;
  logic [WID_W-1:0]     grant;
  logic                 grant_valid;
  logic                 take;
  logic [WARP_SIZE-1:0] sel_mask;

  assign elig = ctx_valid & ready;

  warp_ctx_table #(
    .NUM_WARPS (NUM_WARPS),
    .WARP_SIZE (WARP_SIZE),
    .WID_W     (WID_W)
  ) u_ctx (
    .clk          (clk),
    .rst          (rst),
    .launch_valid (launch_valid),
    .launch_id    (launch_id),
    .launch_mask  (launch_mask),
    .retire_valid (retire_valid),
    .retire_id    (retire_id),
    .rd_id        (grant),
    .rd_mask      (sel_mask),
    .ctx_valid    (ctx_valid)
  );

  warp_rr_picker #(
    .NUM_WARPS (NUM_WARPS),
    .WID_W     (WID_W)
  ) u_pick (
    .clk         (clk),
    .rst         (rst),
    .elig        (elig),
    .take        (take),
    .grant       (grant),
    .grant_valid (grant_valid)
  );

  warp_issue_seq #(
    .WARP_SIZE (WARP_SIZE),
    .NUM_LANES (NUM_LANES),
    .WID_W     (WID_W),
    .GROUPS    (GROUPS),
    .GRP_W     (GRP_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .grant_valid (grant_valid),
    .grant       (grant),
    .sel_mask    (sel_mask),
    .take        (take),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_group (issue_group),
    .lane_en     (lane_en),
    .issue_last  (issue_last)
  );

  // R7: an issued warp was resident when it was chosen.
  p_take_resident_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> ctx_valid[grant] && ready[grant]);

endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] ready = '0;
  logic        launch_valid = 1'b0;
  logic [4:0]  launch_id = '0;
  logic [31:0] launch_mask = '0;
  logic        retire_valid = 1'b0;
  logic [4:0]  retire_id = '0;
  logic        issue_valid;
  logic [4:0]  issue_warp;
  logic [1:0]  issue_group;
  logic [7:0]  lane_en;
  logic        issue_last;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  warp_issue_sched dut (
    .clk(clk), .rst(rst), .ready(ready),
    .launch_valid(launch_valid), .launch_id(launch_id), .launch_mask(launch_mask),
    .retire_valid(retire_valid), .retire_id(retire_id),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_group(issue_group),
    .lane_en(lane_en), .issue_last(issue_last)
  );

  // Launch table: {slot, mask}. Slot order ascending gives the RR order.
  localparam logic [36:0] TAB [6] = '{
    {5'd3,  32'hFFFF_FFFF},
    {5'd7,  32'hC300_00A5},
    {5'd0,  32'h1234_5678},
    {5'd23, 32'h0000_0000},
    {5'd12, 32'h8000_0001},
    {5'd5,  32'h00FF_FF00}
  };
  localparam int ORDER [6] = '{2, 0, 5, 1, 4, 3};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " R7 valid"}, 64'(issue_valid), 64'd0);
    chk({tag, " R7 lanes"}, 64'(lane_en), 64'd0);
    chk({tag, " R7 last"}, 64'(issue_last), 64'd0);
  endtask

  // Observe one whole instruction: four cycles, sampled at negedges.
  task automatic run_instr(input logic [4:0] id, input logic [31:0] m, input string tag);
    for (int g = 0; g < 4; g++) begin
      @(posedge clk);
      @(negedge clk);
      launch_valid = 1'b0;
      retire_valid = 1'b0;
      chk({tag, " R2 valid"}, 64'(issue_valid), 64'd1);
      chk({tag, " R6 warp"}, 64'(issue_warp), 64'(id));
      chk({tag, " R2 group"}, 64'(issue_group), 64'(g));
      chk({tag, " R3 lanes"}, 64'(lane_en), 64'(m[g*8 +: 8]));
      chk({tag, " R2 last"}, 64'(issue_last), 64'(g == 3));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual %0d expected below 5000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_idle("R1 after reset");

    // R8: load the table with ready low; nothing may issue meanwhile
    for (int k = 0; k < 6; k++) begin
      launch_valid = 1'b1;
      launch_id    = TAB[k][36:32];
      launch_mask  = TAB[k][31:0];
      @(posedge clk);
      @(negedge clk);
    end
    launch_valid = 1'b0;
    check_idle("R7 not ready");

    // Table walk: all ready, two full RR rounds back to back (R4 via slot 23)
    ready = '1;
    for (int k = 0; k < 12; k++) begin
      run_instr(TAB[ORDER[k % 6]][36:32], TAB[ORDER[k % 6]][31:0],
                (k % 6 == 5) ? "R4 R5 walk" : "R5 walk");
    end
    ready = '0;
    @(posedge clk);
    @(negedge clk);
    check_idle("R7 drop ready");

    // R7: only slots 7 and 12 ready; others passed over, RR alternates
    ready = 24'h00_1080;
    run_instr(5'd7,  32'hC300_00A5, "R7 skip");
    run_instr(5'd12, 32'h8000_0001, "R7 skip");
    run_instr(5'd7,  32'hC300_00A5, "R6 wrap");
    ready = '0;
    @(posedge clk);
    @(negedge clk);
    check_idle("R7 idle");

    // R9: retire slot 12; only slot 7 issues afterwards
    retire_valid = 1'b1;
    retire_id    = 5'd12;
    @(posedge clk);
    @(negedge clk);
    retire_valid = 1'b0;
    ready = 24'h00_1080;
    run_instr(5'd7, 32'hC300_00A5, "R9 retired");
    run_instr(5'd7, 32'hC300_00A5, "R9 retired");
    ready = '0;
    @(posedge clk);
    @(negedge clk);
    check_idle("R9 idle");

    // R8: relaunch in the choosing cycle; old mask used, new mask next time
    ready        = 24'h00_0020;
    launch_valid = 1'b1;
    launch_id    = 5'd5;
    launch_mask  = 32'hFFFF_FFFF;
    run_instr(5'd5, 32'h00FF_FF00, "R8 snapshot");
    run_instr(5'd5, 32'hFFFF_FFFF, "R8 new mask");
    ready = '0;
    @(posedge clk);
    @(negedge clk);
    check_idle("R8 idle");

    // R9: launch and retire on the same slot in one cycle; launch wins
    launch_valid = 1'b1;
    launch_id    = 5'd9;
    launch_mask  = 32'h0F0F_0F0F;
    retire_valid = 1'b1;
    retire_id    = 5'd9;
    @(posedge clk);
    @(negedge clk);
    launch_valid = 1'b0;
    retire_valid = 1'b0;
    ready = 24'h00_0200;
    run_instr(5'd9, 32'h0F0F_0F0F, "R9 launch wins");

    // R1: reset in mid-instruction clears outputs and resident bits
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_idle("R1 mid reset");
    rst   = 1'b0;
    ready = '1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check_idle("R1 slots empty");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule